// File: doc/BRIEF.md
# Event-Driven GPIO Controller

The block controls up to 64 general-purpose I/O lines through a 16-bit register bus with two addresses. The data address and the mask address each take single indexed writes. A write to the data address sets either the direction or the driven value of one line. A write to the mask address enables or disables change reporting for one line. Every pad input passes through a two-flop synchronizer. A change in the synchronized level of an unmasked line sets a per-line pending flag.

Software drains the changes by reading the data address. Each read returns one event, taken from the lowest-numbered unmasked pending line. The event carries a valid flag, the line's current synchronized level and the line number. The read clears that line's pending flag in the same cycle. A single shared interrupt stays high while any unmasked line has a pending flag. After an interrupt, software keeps reading until the valid flag reads 0.

Top module: `evt_gpio`

## Requirements
- R1: After reset, every line is an input (pad_oe_o all 0), every line drives 0 (pad_o all 0), every line is masked, irq_o is 0, and a data read returns 16'h0000.
- R2: A data write with bit 6 = 0 sets the direction of the line numbered by bits 5:0 to bit 7 (1 = output, drives pad_oe_o high). The new direction is visible after the write's clock edge, and other lines are unchanged.
- R3: A data write with bit 6 = 1 sets the driven value (pad_o) of the line numbered by bits 5:0 to bit 7. The new value is visible after the write's clock edge, and other lines are unchanged.
- R4: A mask write sets the mask of the line numbered by bits 5:0 to bit 7 (1 = masked, 0 = reporting).
- R5: A level change at pad_i of an unmasked line sets its pending flag. irq_o rises after the third rising clock edge that follows the pad change, and not before.
- R6: A level change on a masked line sets no pending flag and does not raise irq_o. A pending flag that exists while its line is masked is neither reported by a read nor counted in irq_o.
- R7: Clearing the mask of a line whose pending flag is still set raises irq_o directly after the mask write's clock edge.
- R8: A data read returns bit 8 = 1 (valid), bit 7 = the current synchronized level and bits 5:0 = the number of the lowest-numbered unmasked pending line. All other bits read 0.
- R9: A data read clears the reported line's pending flag at its clock edge. irq_o falls once no unmasked line is pending, and a data read with nothing pending returns 16'h0000.
- R10: If a new change on the reported line is detected at the same edge as the read that clears it, the pending flag stays set, and the next read reports that line again.
- R11: Reserved write bits (15:8 and 6 of a mask write; 15:8 of a data write) have no effect, and a read of the mask address returns 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = data register, 1 = mask register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the access cycle |
| pad_i | input | 64 | Pad input levels |
| pad_o | output | 64 | Pad output values |
| pad_oe_o | output | 64 | Pad output enables |
| irq_o | output | 1 | Shared change interrupt |

## Verification
Register writes show on pad_oe_o, pad_o and the interrupt after the write's own clock edge. The bench drives each access at a falling edge and checks at the next falling edge. A pad change raises irq_o only after the third rising edge. The bench checks irq_o low after two edges and high after three.

Read data is combinational within the access cycle, so it is sampled just after the falling edge, before the popping rising edge. The same-edge re-arm case is set up so that the read's pop edge is exactly the third edge after a pad toggle.

// File: rtl/evt_gpio_pkg.sv
package evt_gpio_pkg;
  localparam int REG_W    = 16;
  localparam int PIN_W    = 6;
  localparam int MAX_PINS = 1 << PIN_W;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_MASK = 1'b1;

  localparam int B_VALUE = 7;
  localparam int B_KIND  = 6;
  localparam int B_VALID = 8;

  typedef struct packed {
    logic [6:0]       rsvd_hi;
    logic             valid;
    logic             level;
    logic             rsvd_6;
    logic [PIN_W-1:0] pin;
  } evt_word_t;
endpackage

// File: rtl/evt_gpio_sync.sv
module evt_gpio_sync #(
  parameter int N_PINS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] lvl_o,
  output logic [N_PINS-1:0] chg_o
);
  logic [N_PINS-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pad_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl_o = s2_q;
  assign chg_o = s2_q ^ prev_q;
endmodule

// File: rtl/evt_gpio_cfg.sv
module evt_gpio_cfg
  import evt_gpio_pkg::*;
#(
  parameter int N_PINS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_data_i,
  input  logic              wr_mask_i,
  input  logic [PIN_W-1:0]  sel_i,
  input  logic              kind_i,
  input  logic              val_i,
  output logic [N_PINS-1:0] oe_o,
  output logic [N_PINS-1:0] out_o,
  output logic [N_PINS-1:0] mask_o
);
  logic [N_PINS-1:0] oe_q, out_q, mask_q;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic hit;
    assign hit = (sel_i == PIN_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        oe_q[g]   <= 1'b0;
        out_q[g]  <= 1'b0;
        mask_q[g] <= 1'b1;
      end else begin
        if (wr_data_i && hit && !kind_i) oe_q[g]   <= val_i;
        if (wr_data_i && hit &&  kind_i) out_q[g]  <= val_i;
        if (wr_mask_i && hit)            mask_q[g] <= val_i;
      end
    end
  end

  assign oe_o   = oe_q;
  assign out_o  = out_q;
  assign mask_o = mask_q;

  // R2: direction write lands on the selected line
  a_r2_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_i && !kind_i && (int'(sel_i) < N_PINS)) |=> (oe_o[$past(sel_i)] == $past(val_i)));

  // R3: value write lands on the selected line
  a_r3_out_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_i && kind_i && (int'(sel_i) < N_PINS)) |=> (out_o[$past(sel_i)] == $past(val_i)));

  // R4: without a mask write the mask holds
  a_r4_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_i |=> $stable(mask_o));
endmodule

// File: rtl/evt_gpio_events.sv
module evt_gpio_events #(
  parameter int N_PINS = 64,
  localparam int IDX_W = $clog2(N_PINS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] chg_i,
  input  logic [N_PINS-1:0] mask_i,
  input  logic              pop_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  pick_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] pend_q, pend_d, vis;

  assign vis = pend_q & ~mask_i;

  // lowest-numbered visible pending line wins
  always_comb begin
    pick_o = '0;
    for (int i = N_PINS - 1; i >= 0; i--) begin
      if (vis[i]) pick_o = IDX_W'(i);
    end
  end

  assign any_o = |vis;
  assign irq_o = any_o;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pend
    logic set, clr;
    assign set = chg_i[g] & ~mask_i[g];
    assign clr = pop_i & any_o & (pick_o == IDX_W'(g));
    assign pend_d[g] = set | (pend_q[g] & ~clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  // R5: unmasked change is recorded
  a_r5_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chg_i & ~mask_i) != '0) |=> ((pend_q & $past(chg_i & ~mask_i)) == $past(chg_i & ~mask_i)));

  // R6: masked lines never gain a pending flag
  a_r6_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & $past(mask_i)) == '0));

  // R9: popped line is cleared unless it changed again at that edge
  a_r9_pop_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && any_o && !chg_i[pick_o]) |=> !pend_q[$past(pick_o)]);

  // R10: change at pop edge re-arms
  a_r10_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && any_o && chg_i[pick_o] && !mask_i[pick_o]) |=> pend_q[$past(pick_o)]);
endmodule

// File: rtl/evt_gpio.sv
module evt_gpio
  import evt_gpio_pkg::*;
#(
  parameter int N_PINS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(N_PINS);

  logic              wr_data, wr_mask, rd_data;
  logic [N_PINS-1:0] lvl, chg, mask;
  logic              any;
  logic [IDX_W-1:0]  pick;
  evt_word_t         word;
  logic              unused_rsvd;

  assign wr_data = req_i &  we_i & (addr_i == ADDR_DATA);
  assign wr_mask = req_i &  we_i & (addr_i == ADDR_MASK);
  assign rd_data = req_i & ~we_i & (addr_i == ADDR_DATA);
  assign unused_rsvd = ^wdata_i[REG_W-1:B_VALID];

  evt_gpio_sync #(.N_PINS(N_PINS)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pad_i (pad_i),
    .lvl_o (lvl),
    .chg_o (chg)
  );

  evt_gpio_cfg #(.N_PINS(N_PINS)) i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_data_i(wr_data),
    .wr_mask_i(wr_mask),
    .sel_i    (wdata_i[PIN_W-1:0]),
    .kind_i   (wdata_i[B_KIND]),
    .val_i    (wdata_i[B_VALUE]),
    .oe_o     (pad_oe_o),
    .out_o    (pad_o),
    .mask_o   (mask)
  );

  evt_gpio_events #(.N_PINS(N_PINS)) i_events (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .chg_i (chg),
    .mask_i(mask),
    .pop_i (rd_data),
    .any_o (any),
    .pick_o(pick),
    .irq_o (irq_o)
  );

  always_comb begin
    word = '0;
    if (rd_data && any) begin
      word.valid = 1'b1;
      word.level = lvl[pick];
      word.pin   = PIN_W'(pick);
    end
  end

  assign rdata_o = word;

  // R8: a valid event is only returned while the interrupt is up
  a_r8_valid_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && rdata_o[B_VALID]) |-> irq_o);

  // R11: reserved read bits stay zero
  a_r11_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[REG_W-1:B_VALID+1] == '0) && !rdata_o[B_KIND]);

  initial begin
    a_pins_fit: assert (N_PINS >= 2 && N_PINS <= MAX_PINS);
  end
endmodule

// File: tb/test_evt_gpio.sv
module test_evt_gpio;
  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req = 1'b0, we = 1'b0, addr = 1'b0;
  logic [15:0]  wdata = '0;
  logic [15:0]  rdata;
  logic [N-1:0] pad = '0;
  logic [N-1:0] pad_o, pad_oe;
  logic         irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_gpio #(.N_PINS(N)) i_evt_gpio (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .pad_o(pad_o),
    .pad_oe_o(pad_oe), .irq_o(irq)
  );

  // {wdata[15:0], exp_oe, exp_out, pin[5:0]}
  localparam logic [23:0] VEC [8] = '{
    {16'h0080, 1'b1, 1'b0, 6'd0},
    {16'h00C0, 1'b1, 1'b1, 6'd0},
    {16'h00BF, 1'b1, 1'b0, 6'd63},
    {16'h00FF, 1'b1, 1'b1, 6'd63},
    {16'h00D1, 1'b0, 1'b1, 6'd17},
    {16'h0091, 1'b1, 1'b1, 6'd17},
    {16'h0040, 1'b1, 1'b0, 6'd0},
    {16'hFE3F, 1'b0, 1'b1, 6'd63}
  };

  task automatic chk(input bit ok, input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    tick(1);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rd_chk(input logic a, input logic [15:0] exp, input string tag);
    logic [15:0] d;
    rd(a, d);
    chk(d === exp, tag, 64'(d), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick(1);

    // R1 reset state
    chk(pad_oe === '0, "R1 oe", pad_oe, 0);
    chk(pad_o === '0, "R1 out", pad_o, 0);
    chk(irq === 1'b0, "R1 irq", 64'(irq), 0);
    rd_chk(1'b0, 16'h0000, "R1 read");

    // R2/R3 vector table (last entry also R11)
    for (int k = 0; k < 8; k++) begin
      logic [5:0] p;
      p = VEC[k][5:0];
      wr(1'b0, VEC[k][23:8]);
      chk(pad_oe[p] === VEC[k][7], "R2 dir", 64'(pad_oe[p]), 64'(VEC[k][7]));
      chk(pad_o[p] === VEC[k][6], "R3 val", 64'(pad_o[p]), 64'(VEC[k][6]));
    end
    chk(pad_oe === 64'h0000_0000_0002_0001, "R2 others", pad_oe, 64'h0000_0000_0002_0001);
    chk(pad_o === 64'h8000_0000_0002_0000, "R3 R11 others", pad_o, 64'h8000_0000_0002_0000);

    // R6 masked change ignored
    pad[5] = 1'b1;
    tick(5);
    chk(irq === 1'b0, "R6 irq", 64'(irq), 0);
    rd_chk(1'b0, 16'h0000, "R6 read");

    // R4 unmask, R5 timing
    wr(1'b1, 16'h0005);
    chk(irq === 1'b0, "R4 no stale", 64'(irq), 0);
    pad[5] = 1'b0;
    tick(2);
    chk(irq === 1'b0, "R5 early", 64'(irq), 0);
    tick(1);
    chk(irq === 1'b1, "R5 irq", 64'(irq), 1);
    rd_chk(1'b0, 16'h0105, "R8 read pin5");
    chk(irq === 1'b0, "R9 irq drop", 64'(irq), 0);
    rd_chk(1'b0, 16'h0000, "R9 empty");

    // R8 priority
    wr(1'b1, 16'h0009);
    wr(1'b1, 16'h0028);
    pad[9] = 1'b1; pad[40] = 1'b1;
    tick(3);
    rd_chk(1'b0, 16'h0189, "R8 lowest");
    chk(irq === 1'b1, "R9 irq held", 64'(irq), 1);
    rd_chk(1'b0, 16'h01A8, "R8 next");
    rd_chk(1'b0, 16'h0000, "R9 drained");

    // R7 pending kept while masked
    pad[9] = 1'b0;
    tick(3);
    chk(irq === 1'b1, "R5 pin9", 64'(irq), 1);
    wr(1'b1, 16'h0089);
    chk(irq === 1'b0, "R6 masked pend", 64'(irq), 0);
    rd_chk(1'b0, 16'h0000, "R6 masked read");
    wr(1'b1, 16'h0009);
    chk(irq === 1'b1, "R7 unmask irq", 64'(irq), 1);
    rd_chk(1'b0, 16'h0109, "R7 read");

    // R10 re-arm at pop edge
    pad[40] = 1'b0;
    tick(3);
    pad[40] = 1'b1;
    tick(2);
    rd_chk(1'b0, 16'h01A8, "R10 first");
    rd_chk(1'b0, 16'h01A8, "R10 rearm");
    rd_chk(1'b0, 16'h0000, "R10 drained");

    // R11 mask read and reserved mask bits
    rd_chk(1'b1, 16'h0000, "R11 mask read");
    wr(1'b1, 16'hFFC5);
    pad[5] = 1'b1;
    tick(4);
    chk(irq === 1'b0, "R11 mask rsvd", 64'(irq), 0);
    rd_chk(1'b0, 16'h0000, "R11 read");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule